// File: doc/BRIEF.md
# Four-Channel Shared-Counter PWM Generator

This block drives four pulse-width-modulated outputs from a single period counter. The counter advances on a tick taken from the system clock through a power-of-two divider. It either runs as a sawtooth, which gives edge-aligned pulses, or as a triangle, which gives center-aligned pulses. Each channel compares the counter with its own compare value. The channel pin is high while the counter is below that value.

A loader supplies four compare words and a top word with a one-cycle valid pulse. These words go into a pending set. The running set (compares, top and counting mode) takes the pending set only at a period boundary, so a waveform never changes shape mid-period. At each boundary the block raises a one-cycle period-end strobe, which tells the loader when to supply the next set. The period top comes either from a static input word or from the loader stream, chosen by a select input.

Top module: `pwm4_gen`

## Requirements
- R1: While enabled, the counter advances once every 2^N clock cycles, where N is `div_code` (0..7). A divider code of 0 advances the counter on every cycle.
- R2: With `center_mode` = 0, the counter runs 0, 1, ..., top and then returns to 0. One period is top+1 ticks.
- R3: With `center_mode` = 1, the counter runs up from 0 to top and then down to 0. One period is 2*top ticks, and a top of 0 gives a 1-tick period.
- R4: Each output is high while the counter is below that channel's compare value and low otherwise. A compare value of 0 keeps the output low for the whole period. A compare value equal to or above top keeps it high for the whole period.
- R5: Only bits 14:0 of each 16-bit compare or top word are used, and bit 15 has no effect. The top is therefore at most 32767.
- R6: After reset the active top and the loader's pending top are 1000, all compares are 0, the counter is 0, and every output and the strobe are low.
- R7: A word set is captured when `ld_valid` is high. The running compares, top and counting mode change only at a period boundary, or while the block is disabled. In either case they take the pending set.
- R8: With `top_from_ld` = 1, the top taken at a boundary is the last loaded `ld_top`. With `top_from_ld` = 0, it is `cfg_top`.
- R9: `period_end` is high for exactly the one cycle after each boundary tick. In that cycle the counter is 0.
- R10: While `enable` is low, the outputs and the strobe are low (from the next cycle on), the counter and divider are cleared, and the running set follows the pending set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the generator; low stops it and forces outputs low |
| div_code | input | 3 | Divider exponent N, tick every 2^N clocks |
| center_mode | input | 1 | 0 = sawtooth counting, 1 = triangle counting |
| top_from_ld | input | 1 | 1 = top from loader stream, 0 = top from `cfg_top` |
| cfg_top | input | 16 | Static top word (bit 15 ignored) |
| ld_valid | input | 1 | Capture strobe for the loader words |
| ld_cmp | input | 64 | Four compare words, channel k in bits 16k+15:16k (bit 15 of each ignored) |
| ld_top | input | 16 | Top word from the loader (bit 15 ignored) |
| pwm_out | output | 4 | Channel outputs, bit k is channel k |
| period_end | output | 1 | One-cycle strobe at each period boundary |

## Verification
The bench attacks the compare extremes. A compare of 0 must stay dark, and a compare equal to top must stay lit all period: an off-by-one comparator would show a one-tick gap or a one-tick pulse. It loads words with bit 15 set. A design that kept the bit would stretch the period or pin a channel high. It reloads values mid-period and toggles the counting mode. A design that applied them at once would reshape the current period, which the cycle-by-cycle scoreboard flags. It measures triangle periods, including the turning points, where a doubled or skipped top or zero count would give 2*top±1. It also measures divided ticks and a 1001-cycle period after reset, which catches a wrong divider mask or a wrong reset top.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;

    localparam int CNT_W     = 15;
    localparam int WORD_W    = 16;
    localparam int CODE_W    = 3;
    localparam int TOP_RESET = 1000;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {
        CM_SAW = 1'b0,
        CM_TRI = 1'b1
    } cmode_e;

    typedef struct packed {
        cnt_t   top;
        cmode_e mode;
    } frame_cfg_t;

    function automatic cnt_t word_to_cnt(input logic [WORD_W-1:0] w);
        return w[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/pwm4_divider.sv
module pwm4_divider
    import pwm4_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [CW-1:0] code,
    output logic          tick
);
    localparam int DW = (1 << CW) - 1;

    logic [DW-1:0] acc_q;
    logic [DW:0]   span;
    logic [DW-1:0] mask;

    always_comb begin
        span = ({{DW{1'b0}}, 1'b1} << code) - {{DW{1'b0}}, 1'b1};
        mask = span[DW-1:0];
        tick = run && ((acc_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) acc_q <= '0;
        else             acc_q <= acc_q + 1'b1;
    end
endmodule

// File: rtl/pwm4_counter.sv
module pwm4_counter
    import pwm4_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  logic   tick,
    input  cnt_t   top,
    input  cmode_e mode,
    output cnt_t   cnt,
    output logic   wrap
);
    cnt_t cnt_q, cnt_d;
    logic down_q, down_d;

    always_comb begin
        cnt_d  = cnt_q;
        down_d = down_q;
        wrap   = 1'b0;
        if (tick) begin
            if (mode == CM_SAW) begin
                if (cnt_q >= top) begin
                    cnt_d = '0;
                    wrap  = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end else begin
                if (!down_q && (cnt_q < top)) begin
                    cnt_d = cnt_q + 1'b1;
                end else if (cnt_q <= cnt_t'(1)) begin
                    cnt_d  = '0;
                    down_d = 1'b0;
                    wrap   = 1'b1;
                end else begin
                    cnt_d  = cnt_q - 1'b1;
                    down_d = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            down_q <= down_d;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/pwm4_channel.sv
module pwm4_channel
    import pwm4_pkg::*;
(
    input  logic run,
    input  cnt_t cnt,
    input  cnt_t top,
    input  cnt_t cmp,
    output logic out
);
    logic nonzero, below, saturate;

    always_comb begin
        nonzero  = (cmp != '0);
        below    = (cnt < cmp);
        saturate = (cmp >= top);
        out      = run && nonzero && (below || saturate);
    end
endmodule

// File: rtl/pwm4_gen.sv
module pwm4_gen
    import pwm4_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic [CODE_W-1:0]   div_code,
    input  logic                center_mode,
    input  logic                top_from_ld,
    input  logic [WORD_W-1:0]   cfg_top,
    input  logic                ld_valid,
    input  logic [NCH*WORD_W-1:0] ld_cmp,
    input  logic [WORD_W-1:0]   ld_top,
    output logic [NCH-1:0]      pwm_out,
    output logic                period_end
);
    cnt_t       pend_cmp [NCH];
    cnt_t       pend_top_ld;
    cnt_t       act_cmp  [NCH];
    frame_cfg_t act_cfg, pend_cfg;
    cnt_t       top_act;
    cnt_t       cnt_q;
    logic       run_q;
    logic       tick, wrap;
    logic       take;

    always_comb begin
        pend_cfg.top  = top_from_ld ? pend_top_ld : word_to_cnt(cfg_top);
        pend_cfg.mode = center_mode ? CM_TRI : CM_SAW;
        take          = !enable || wrap;
    end

    assign top_act = act_cfg.top;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_top_ld  <= cnt_t'(TOP_RESET);
            act_cfg.top  <= cnt_t'(TOP_RESET);
            act_cfg.mode <= CM_SAW;
            run_q        <= 1'b0;
            period_end   <= 1'b0;
        end else begin
            run_q      <= enable;
            period_end <= enable && wrap;
            if (ld_valid) pend_top_ld <= word_to_cnt(ld_top);
            if (take)     act_cfg     <= pend_cfg;
        end
    end

    pwm4_divider #(.CW(CODE_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (enable),
        .code (div_code),
        .tick (tick)
    );

    pwm4_counter u_cnt (
        .clk  (clk),
        .rst  (rst),
        .run  (enable),
        .tick (tick),
        .top  (act_cfg.top),
        .mode (act_cfg.mode),
        .cnt  (cnt_q),
        .wrap (wrap)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_cmp[k] <= '0;
                act_cmp[k]  <= '0;
            end else begin
                if (ld_valid) pend_cmp[k] <= word_to_cnt(ld_cmp[k*WORD_W +: WORD_W]);
                if (take)     act_cmp[k]  <= pend_cmp[k];
            end
        end

        pwm4_channel u_ch (
            .run (run_q),
            .cnt (cnt_q),
            .top (act_cfg.top),
            .cmp (act_cmp[k]),
            .out (pwm_out[k])
        );
    end
endmodule

// File: rtl/pwm4_gen_chk.sv
module pwm4_gen_chk
    import pwm4_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           enable,
    input logic [NCH-1:0] pwm_out,
    input logic           period_end,
    input cnt_t           cnt,
    input cnt_t           top_act
);
    // R10: a stopped generator is silent one cycle later
    assert_idle_low_R10: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (pwm_out == '0) && !period_end);

    // R9: the strobe coincides with a counter sitting at zero
    assert_strobe_at_zero_R9: assert property (@(posedge clk) disable iff (rst)
        period_end |-> (cnt == '0));

    // R2: the counter never passes the running top
    assert_cnt_within_top_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= top_act);

    // R7: while running, the top only moves together with a boundary strobe
    assert_top_only_at_boundary_R7: assert property (@(posedge clk) disable iff (rst)
        enable |=> (period_end || $stable(top_act)));
endmodule

bind pwm4_gen pwm4_gen_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .pwm_out    (pwm_out),
    .period_end (period_end),
    .cnt        (cnt_q),
    .top_act    (top_act)
);

// File: tb/pwm4_gen_bench.sv
module pwm4_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [2:0]  div_code = '0;
    logic        center_mode = 1'b0;
    logic        top_from_ld = 1'b1;
    logic [15:0] cfg_top = '0;
    logic        ld_valid = 1'b0;
    logic [63:0] ld_cmp = '0;
    logic [15:0] ld_top = '0;
    logic [3:0]  pwm_out;
    logic        period_end;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm4_gen u_pwm4_gen (.*);

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R6";

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- reference model and scoreboard ----------------
    typedef struct { logic [3:0] pwm; logic pe; } exp_t;
    exp_t exp_q[$];

    int m_pre, m_cnt, m_top, m_ptop;
    bit m_dn, m_run, m_pe, m_tri;
    int m_cmp[4], m_pcmp[4];

    always @(posedge clk) begin
        exp_t e;
        int   ptop_eff;
        bit   tk, bnd;
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_dn = 0; m_run = 0; m_pe = 0;
            m_top = 1000; m_ptop = 1000; m_tri = 0;
            for (int k = 0; k < 4; k++) begin m_cmp[k] = 0; m_pcmp[k] = 0; end
        end else begin
            ptop_eff = top_from_ld ? m_ptop : int'(cfg_top[14:0]);
            if (!enable) begin
                m_pre = 0; m_cnt = 0; m_dn = 0; m_pe = 0;
                m_top = ptop_eff; m_tri = center_mode;
                for (int k = 0; k < 4; k++) m_cmp[k] = m_pcmp[k];
            end else begin
                tk  = (m_pre % (1 << div_code)) == ((1 << div_code) - 1);
                m_pre = (m_pre + 1) % 128;
                bnd = 0;
                if (tk) begin
                    if (!m_tri) begin
                        if (m_cnt == m_top) begin m_cnt = 0; bnd = 1; end
                        else m_cnt++;
                    end else if (!m_dn && m_cnt < m_top) m_cnt++;
                    else if (m_cnt <= 1) begin m_cnt = 0; m_dn = 0; bnd = 1; end
                    else begin m_cnt--; m_dn = 1; end
                end
                m_pe = bnd;
                if (bnd) begin
                    m_top = ptop_eff; m_tri = center_mode;
                    for (int k = 0; k < 4; k++) m_cmp[k] = m_pcmp[k];
                end
            end
            m_run = enable;
            if (ld_valid) begin
                m_ptop = int'(ld_top[14:0]);
                for (int k = 0; k < 4; k++) m_pcmp[k] = int'(ld_cmp[k*16 +: 15]);
            end
        end
        for (int k = 0; k < 4; k++)
            e.pwm[k] = m_run && m_cmp[k] != 0 && (m_cnt < m_cmp[k] || m_cmp[k] >= m_top);
        e.pe = m_pe;
        exp_q.push_back(e);
    end

    always @(negedge clk) begin
        exp_t e;
        if (exp_q.size() != 0) begin
            e = exp_q.pop_front();
            check(pwm_out == e.pwm, {cur_req, " pwm_out"}, int'(pwm_out), int'(e.pwm));
            check(period_end == e.pe, {cur_req, " period_end"}, int'(period_end), int'(e.pe));
        end
    end

    // ---------------- driver tasks ----------------
    task automatic load(input int c0, input int c1, input int c2, input int c3, input int t);
        @(negedge clk);
        ld_cmp   = {c3[15:0], c2[15:0], c1[15:0], c0[15:0]};
        ld_top   = t[15:0];
        ld_valid = 1'b1;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    int per_len;
    int hi_cnt[4];

    task automatic wait_strobe();
        int guard = 0;
        do begin @(negedge clk); guard++; end while (!period_end && guard < 5000);
    endtask

    task automatic measure();
        wait_strobe();
        per_len = 0;
        for (int k = 0; k < 4; k++) hi_cnt[k] = 0;
        do begin
            for (int k = 0; k < 4; k++) hi_cnt[k] += int'(pwm_out[k]);
            @(negedge clk);
            per_len++;
        end while (!period_end && per_len < 5000);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("[TB] FAIL watchdog actual=expired expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        check(pwm_out == 4'h0, "R6 outputs in reset", int'(pwm_out), 0);
        check(!period_end, "R6 strobe in reset", int'(period_end), 0);
        rst = 1'b0;

        // R6: default top 1000 from the loader path
        cur_req = "R6";
        @(negedge clk); enable = 1'b1;
        measure();
        check(per_len == 1001, "R6 reset top period", per_len, 1001);
        check(hi_cnt[0] == 0, "R6 reset compare", hi_cnt[0], 0);
        enable = 1'b0;

        // R2/R4: sawtooth, top 9, compare extremes
        cur_req = "R4";
        load(0, 3, 9, 20, 9);
        @(negedge clk); enable = 1'b1;
        measure();
        check(per_len == 10, "R2 sawtooth period", per_len, 10);
        check(hi_cnt[0] == 0,  "R4 compare zero low", hi_cnt[0], 0);
        check(hi_cnt[1] == 3,  "R4 compare 3 width", hi_cnt[1], 3);
        check(hi_cnt[2] == 10, "R4 compare equal top high", hi_cnt[2], 10);
        check(hi_cnt[3] == 10, "R4 compare above top high", hi_cnt[3], 10);
        @(negedge clk);
        check(!period_end, "R9 strobe one cycle", int'(period_end), 0);

        // R5: bit 15 set on every word
        cur_req = "R5";
        load(16'h8000, 16'h8005, 16'h8002, 16'h8009, 16'h8009);
        measure(); measure();
        check(per_len == 10, "R5 top bit15 ignored", per_len, 10);
        check(hi_cnt[0] == 0, "R5 compare bit15 ignored", hi_cnt[0], 0);
        check(hi_cnt[1] == 5, "R5 compare 5 width", hi_cnt[1], 5);

        // R7: mid-period reload plus mode change; scoreboard watches every cycle
        cur_req = "R7";
        wait_strobe();
        repeat (3) @(negedge clk);
        center_mode = 1'b1;
        load(0, 3, 5, 1, 5);
        measure(); measure();
        // R3: triangle, top 5
        cur_req = "R3";
        check(per_len == 10, "R3 triangle period", per_len, 10);
        check(hi_cnt[1] == 5, "R3 centered width", hi_cnt[1], 5);
        check(hi_cnt[2] == 10, "R3 compare equal top high", hi_cnt[2], 10);
        check(hi_cnt[3] == 1, "R3 compare 1 width", hi_cnt[3], 1);

        // R1: divided ticks
        cur_req = "R1";
        div_code = 3'd1;
        measure(); measure();
        check(per_len == 20, "R1 divide by 2 triangle", per_len, 20);
        center_mode = 1'b0;
        div_code = 3'd3;
        load(2, 2, 2, 2, 4);
        measure(); measure();
        check(per_len == 40, "R1 divide by 8 sawtooth", per_len, 40);
        check(hi_cnt[0] == 16, "R1 divided width", hi_cnt[0], 16);

        // R8: top from static input
        cur_req = "R8";
        div_code = 3'd0;
        cfg_top = 16'h8007;
        top_from_ld = 1'b0;
        measure(); measure();
        check(per_len == 8, "R8 static top", per_len, 8);

        // R3: zero top in triangle mode
        cur_req = "R3";
        top_from_ld = 1'b1;
        center_mode = 1'b1;
        load(1, 0, 1, 0, 0);
        measure(); measure();
        check(per_len == 1, "R3 zero top period", per_len, 1);

        // R10: stop mid-period
        cur_req = "R10";
        center_mode = 1'b0;
        load(3, 3, 3, 3, 9);
        measure(); measure();
        repeat (2) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(pwm_out == 4'h0, "R10 outputs low when stopped", int'(pwm_out), 0);
        repeat (5) @(negedge clk);
        check(!period_end, "R10 no strobe when stopped", int'(period_end), 0);
        enable = 1'b1;
        measure();
        check(per_len == 10, "R10 restart period", per_len, 10);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule